// File: doc/BRIEF.md
# Presettable Reversible Counter with Cascade Strobes

This block is a small synchronous counter that steps by one on each rising clock edge in either direction. An active-low enable gates counting. A single direction input chooses up or down. A parameter selects a plain binary wrap over the whole register or a decimal (0 to 9) wrap. An active-low preset input forces the register to a parallel value at once, without waiting for a clock edge, and holds it there for as long as the preset stays low.

Two outputs let several stages be chained. A terminal flag is high whenever the register holds the last value of the current direction: the top value when stepping up, zero when stepping down. Because the flag ignores the enable, a downstream stage can combine it with the upstream enable as look-ahead logic. An active-low strobe carries the same condition qualified by the enable and by the low phase of the clock. It gives one low pulse per wrap, as wide as the clock's low half.

Top module: `updn_cascade_counter`

## Requirements
- R1: With the preset input high, a rising edge with `rst` high clears the count to 0.
- R2: While `cnt_en_n` is high, the count does not change on clock edges, whatever `dir_down` does.
- R3: With `cnt_en_n` low and `dir_down` low, each rising edge adds one. In binary mode the count wraps from 2^WIDTH-1 to 0.
- R4: With `cnt_en_n` low and `dir_down` high, each rising edge subtracts one. In binary mode the count wraps from 0 to 2^WIDTH-1.
- R5: In decimal mode, counting up goes from 9 to 0 and counting down goes from 0 to 9.
- R6: In decimal mode, a preset value from 10 to 15 becomes 0 on the next up step and 9 on the next down step.
- R7: While `load_n` is low, `count_o` equals `load_data` with no clock edge needed. After `load_n` returns high, that value is kept until the next enabled edge.
- R8: While `load_n` is low, rising edges change nothing, even with the enable active or `rst` high.
- R9: `term_o` is high exactly when the count is at the top value with `dir_down` low (15 binary, 9 decimal), or at 0 with `dir_down` high. It does not depend on `cnt_en_n`.
- R10: `ripple_n_o` is low exactly while `clk` is low, `cnt_en_n` is low and `term_o` is high. It is high at all other times.
- R11: Two decimal stages chained so that the upper stage is enabled only when the lower stage is enabled and its `term_o` is high form a two-digit counter that wraps 99 to 0 up and 0 to 99 down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| load_n | input | 1 | Active-low asynchronous preset |
| load_data | input | WIDTH | Preset value |
| count_o | output | WIDTH | Current count |
| term_o | output | 1 | Terminal-count flag for the present direction |
| ripple_n_o | output | 1 | Active-low cascade strobe, clock-qualified |

## Verification
Two collisions matter most. The first is a preset held low across a rising edge with the enable active and reset asserted. Here the bench expects the preset value to survive the edge and counting to resume from it once the preset is released. The second is an enabled edge that lands on a terminal value, where the wrap, the terminal flag and the strobe all act together. Both the binary and decimal instances are driven through every wrap in each direction, and the two-digit chain is run through 99 and back through 0. A behavioural reference compares every output on each clock, in both clock phases for the strobe.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;

    typedef struct packed {
        logic      active;
        step_dir_e dir;
    } step_ctl_s;

    // Largest value reached before an upward wrap
    function automatic int top_value(bit decimal, int width);
        return decimal ? 9 : ((1 << width) - 1);
    endfunction

endpackage

// File: rtl/updn_step.sv
module updn_step
    import updn_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit DECIMAL = 1'b0
) (
    input  logic [WIDTH-1:0] cur_i,
    input  step_dir_e        dir_i,
    output logic [WIDTH-1:0] nxt_o
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(top_value(DECIMAL, WIDTH));

    generate
        if (DECIMAL) begin : g_dec
            always_comb begin
                if (dir_i == STEP_UP)
                    nxt_o = (cur_i >= LAST) ? '0 : cur_i + 1'b1;
                else
                    nxt_o = (cur_i == '0 || cur_i > LAST) ? LAST : cur_i - 1'b1;
            end
        end else begin : g_bin
            always_comb begin
                if (dir_i == STEP_UP)
                    nxt_o = cur_i + 1'b1;
                else
                    nxt_o = cur_i - 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit DECIMAL = 1'b0
) (
    input  logic [WIDTH-1:0] cur_i,
    input  step_dir_e        dir_i,
    output logic             term_o
);
    localparam logic [WIDTH-1:0] LAST = WIDTH'(top_value(DECIMAL, WIDTH));

    always_comb begin
        if (dir_i == STEP_UP)
            term_o = (cur_i == LAST);
        else
            term_o = (cur_i == '0);
    end
endmodule

// File: rtl/updn_ripple.sv
module updn_ripple
    import updn_pkg::*;
(
    input  logic      clk,
    input  step_ctl_s ctl_i,
    input  logic      term_i,
    output logic      ripple_n_o
);
    // Low only during the low clock phase of an enabled terminal cycle
    always_comb ripple_n_o = ~(~clk & ctl_i.active & term_i);
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
    import updn_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter bit DECIMAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    input  logic             load_n,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] count_o,
    output logic             term_o,
    output logic             ripple_n_o
);
    localparam logic [WIDTH-1:0] TOP_VAL = WIDTH'(top_value(DECIMAL, WIDTH));

    step_ctl_s        ctl;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_nxt;
    logic             at_term;

    always_comb begin
        ctl.active = ~cnt_en_n;
        ctl.dir    = step_dir_e'(dir_down);
    end

    updn_step #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_step (
        .cur_i (state_q),
        .dir_i (ctl.dir),
        .nxt_o (state_nxt)
    );

    // Preset is asynchronous and outranks both reset and counting
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)
            state_q <= load_data;
        else if (rst)
            state_q <= '0;
        else if (ctl.active)
            state_q <= state_nxt;
    end

    updn_term #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) u_term (
        .cur_i  (state_q),
        .dir_i  (ctl.dir),
        .term_o (at_term)
    );

    updn_ripple u_ripple (
        .clk        (clk),
        .ctl_i      (ctl),
        .term_i     (at_term),
        .ripple_n_o (ripple_n_o)
    );

    assign count_o = state_q;
    assign term_o  = at_term;
endmodule

// File: rtl/updn_counter_chk.sv
// Properties assume every preset pulse spans at least one rising edge.
module updn_counter_chk #(
    parameter int               WIDTH   = 4,
    parameter logic [WIDTH-1:0] TOP_VAL = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en_n,
    input logic             dir_down,
    input logic             load_n,
    input logic [WIDTH-1:0] load_data,
    input logic [WIDTH-1:0] count_o,
    input logic             term_o,
    input logic             ripple_n_o
);
    a_r7_load_transparent: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> count_o == load_data);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && $past(cnt_en_n))
        |-> $stable(count_o));

    a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && !$past(cnt_en_n)
         && !$past(dir_down) && $past(count_o) < TOP_VAL)
        |-> count_o == $past(count_o) + 1'b1);

    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && !$past(cnt_en_n)
         && $past(dir_down) && $past(count_o) != '0 && $past(count_o) <= TOP_VAL)
        |-> count_o == $past(count_o) - 1'b1);

    a_r9_term_bottom: assert property (@(posedge clk) disable iff (rst)
        (dir_down && count_o == '0) |-> term_o);

    a_r10_ripple_low: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en_n && term_o) |-> !ripple_n_o);

    a_r10_ripple_idle: assert property (@(negedge clk) disable iff (rst)
        ripple_n_o);
endmodule

bind updn_cascade_counter updn_counter_chk #(
    .WIDTH   (WIDTH),
    .TOP_VAL (TOP_VAL)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cnt_en_n   (cnt_en_n),
    .dir_down   (dir_down),
    .load_n     (load_n),
    .load_data  (load_data),
    .count_o    (count_o),
    .term_o     (term_o),
    .ripple_n_o (ripple_n_o)
);

// File: tb/updn_cascade_counter_tb_top.sv
`timescale 1ns/1ps
module updn_cascade_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en_n = 1'b1;
    logic       dir_down = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] load_data = 4'd0;
    logic       en_c_n = 1'b1;
    logic       dir_c = 1'b0;

    logic [3:0] cnt_b, cnt_d, cnt_lo, cnt_hi;
    logic       term_b, term_d, term_lo, term_hi;
    logic       rip_b, rip_d, rip_lo, rip_hi;
    logic       en_hi_n;

    int n_chk = 0;
    int n_err = 0;
    string phase = "R1";
    bit started = 1'b0;
    int ref_b = 0, ref_d = 0, ref_c = 0;

    always #10 clk = ~clk;

    updn_cascade_counter #(.WIDTH(4), .DECIMAL(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
        .load_n(load_n), .load_data(load_data),
        .count_o(cnt_b), .term_o(term_b), .ripple_n_o(rip_b));

    updn_cascade_counter #(.WIDTH(4), .DECIMAL(1'b1)) dut_dec (
        .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
        .load_n(load_n), .load_data(load_data),
        .count_o(cnt_d), .term_o(term_d), .ripple_n_o(rip_d));

    // R11 chain: upper digit enabled by look-ahead of the lower digit
    assign en_hi_n = ~(~en_c_n & term_lo);

    updn_cascade_counter #(.WIDTH(4), .DECIMAL(1'b1)) dut_lo (
        .clk(clk), .rst(rst), .cnt_en_n(en_c_n), .dir_down(dir_c),
        .load_n(1'b1), .load_data(4'd0),
        .count_o(cnt_lo), .term_o(term_lo), .ripple_n_o(rip_lo));

    updn_cascade_counter #(.WIDTH(4), .DECIMAL(1'b1)) dut_hi (
        .clk(clk), .rst(rst), .cnt_en_n(en_hi_n), .dir_down(dir_c),
        .load_n(1'b1), .load_data(4'd0),
        .count_o(cnt_hi), .term_o(term_hi), .ripple_n_o(rip_hi));

    // Behavioural reference
    always @(posedge clk or negedge load_n) begin
        if (!load_n) begin
            ref_b = int'(load_data);
            ref_d = int'(load_data);
        end else if (rst) begin
            ref_b = 0;
            ref_d = 0;
        end else if (!cnt_en_n) begin
            ref_b = dir_down ? (ref_b + 15) % 16 : (ref_b + 1) % 16;
            if (dir_down) ref_d = (ref_d == 0 || ref_d > 9) ? 9 : ref_d - 1;
            else          ref_d = (ref_d >= 9) ? 0 : ref_d + 1;
        end
    end

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) ref_c = 0;
        else if (!en_c_n) ref_c = dir_c ? (ref_c + 99) % 100 : (ref_c + 1) % 100;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    function automatic int exp_term(input int v, input logic dn, input int top);
        return dn ? int'(v == 0) : int'(v == top);
    endfunction

    // Low clock phase: counts, flags and strobes
    always @(negedge clk) begin
        #3;
        if (started) begin
            string dtag;
            dtag = (phase == "R3" || phase == "R4") ? "R5" : phase;
            chk(phase, int'(cnt_b), ref_b);
            chk(dtag, int'(cnt_d), ref_d);
            chk("R9", int'(term_b), exp_term(ref_b, dir_down, 15));
            chk("R9", int'(term_d), exp_term(ref_d, dir_down, 9));
            chk("R10", int'(rip_b), int'(!(!cnt_en_n && exp_term(ref_b, dir_down, 15) == 1)));
            chk("R10", int'(rip_d), int'(!(!cnt_en_n && exp_term(ref_d, dir_down, 9) == 1)));
            chk("R11", int'(cnt_hi) * 10 + int'(cnt_lo), ref_c);
        end
    end

    // High clock phase: strobes must be idle
    always @(posedge clk) begin
        #3;
        if (started) begin
            chk("R10", int'(rip_b), 1);
            chk("R10", int'(rip_lo), 1);
        end
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    // Chain stimulus runs alongside the main sequence
    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
        #1 en_c_n = 1'b0; dir_c = 1'b0;
        cycles(130);
        dir_c = 1'b1;
        cycles(60);
        en_c_n = 1'b1;
    end

    initial begin
        // R1 reset state
        phase = "R1";
        cycles(3);
        rst = 1'b0;
        cycles(1);
        chk("R1", int'(cnt_b), 0);

        // R3 up through binary wrap (R5 on the decimal copy)
        phase = "R3";
        cnt_en_n = 1'b0; dir_down = 1'b0;
        cycles(20);

        // R4 down through wrap
        phase = "R4";
        dir_down = 1'b1;
        cycles(20);

        // R2 hold with direction wiggling
        phase = "R2";
        cnt_en_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            dir_down = ~dir_down;
            cycles(1);
        end

        // R7 immediate preset with enable off, then kept after release
        phase = "R7";
        load_data = 4'd5; load_n = 1'b0;
        #1 chk("R7", int'(cnt_b), 5);
        cycles(1);
        load_n = 1'b1;
        cycles(3);
        chk("R7", int'(cnt_b), 5);

        // R6 out-of-range decimal presets
        phase = "R6";
        load_data = 4'd12; load_n = 1'b0;
        cycles(1);
        load_n = 1'b1; dir_down = 1'b0; cnt_en_n = 1'b0;
        cycles(1);
        chk("R6", int'(cnt_d), 0);
        cnt_en_n = 1'b1;
        load_data = 4'd14; load_n = 1'b0;
        cycles(1);
        load_n = 1'b1; dir_down = 1'b1; cnt_en_n = 1'b0;
        cycles(1);
        chk("R6", int'(cnt_d), 9);

        // R8 preset held across enabled edges and a reset
        phase = "R8";
        dir_down = 1'b0;
        load_data = 4'd7; load_n = 1'b0;
        cycles(1);
        rst = 1'b1;
        cycles(1);
        rst = 1'b0;
        cycles(1);
        chk("R8", int'(cnt_b), 7);
        load_n = 1'b1;
        cycles(2);
        chk("R8", int'(cnt_b), 9);

        // R9 flag with enable off at both ends
        phase = "R9";
        cnt_en_n = 1'b1;
        load_data = 4'd15; load_n = 1'b0;
        cycles(1);
        load_n = 1'b1;
        dir_down = 1'b0;
        #1 chk("R9", int'(term_b), 1);
        dir_down = 1'b1;
        #1 chk("R9", int'(term_b), 0);
        load_data = 4'd0; load_n = 1'b0;
        cycles(1);
        load_n = 1'b1;
        #1 chk("R9", int'(term_b), 1);
        chk("R10", int'(rip_b), 1);
        cycles(2);

        // R1 reset while counting
        phase = "R1";
        cnt_en_n = 1'b0; dir_down = 1'b0;
        cycles(5);
        rst = 1'b1;
        cycles(1);
        chk("R1", int'(cnt_b), 0);
        rst = 1'b0;
        cycles(200);
        finish_sim();
    end
endmodule